// File: doc/BRIEF.md
# Set-Resizable Direct-Mapped Instruction Cache

A read-only, direct-mapped instruction cache whose capacity can be changed at run time by changing the number of sets it uses. The associativity stays at one way. A size-select input picks how many line-address bits form the set index. Sets beyond the chosen count are treated as powered off. Their contents are lost, and they come back empty when re-enabled.

Each fetch presents a line address. One cycle later the cache reports hit or miss together with the stored line. On a miss it raises a refill request that carries the line address. The next level answers through a refill port, which writes data, tag and valid bit in a single cycle.

Every stored tag keeps all line-address bits above the smallest allowed index width. A line that stays resident after a resize therefore can never match an address that now folds onto the same set. Because of this, no flush is needed for the sets that remain enabled.

Top module: `setsize_icache`

## Requirements
- R1: After reset every line is invalid, the active index width is the largest allowed (6 bits, 64 sets) and no response is signalled; the first lookup of any address misses.
- R2: A lookup accepted on a clock edge (reqValid high) produces rspValid during the following cycle only; rspHit is high only with rspValid, and on a hit rspData is the line last refilled for that address.
- R3: A miss raises refillReq in the same cycle as rspValid, with refillReqLine equal to the looked-up line address; a hit never raises refillReq.
- R4: One refill cycle writes data, tag and valid bit, so a lookup of that line accepted at the next edge hits.
- R5: The set index is line-address bits [width-1:0] and the stored tag is line-address bits [13:3] (all bits above the minimum 3-bit index); a line address in the same set with a different tag misses, and its refill evicts the previous line.
- R6: After the width shrinks, an address that now folds onto a resident line's set but differs in any bit above the minimum index misses.
- R7: Shrinking the width leaves every line in the sets that remain enabled valid and hitting, with no flush.
- R8: Shrinking clears the valid bit of every set whose number is at least 2^newWidth; when those sets are enabled again, lookups to them miss.
- R9: A new size is taken only at an edge where reqValid is low; lookups accepted while reqValid is held high keep using the old width.
- R10: The active width is 3 + sizeSel, limited to 6 (sizeSel 0 gives 8 sets, 1 gives 16, 3 gives 64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sizeSel | input | 2 | Requested index width minus the minimum width |
| reqValid | input | 1 | Lookup request strobe |
| reqLine | input | 14 | Line address of the lookup |
| rspValid | output | 1 | Lookup result available this cycle |
| rspHit | output | 1 | Lookup found a valid line with matching tag |
| rspData | output | 32 | Stored line contents |
| refillReq | output | 1 | Miss: line must be fetched from the next level |
| refillReqLine | output | 14 | Line address to fetch |
| refillValid | input | 1 | Refill write strobe |
| refillLine | input | 14 | Line address being refilled |
| refillData | input | 32 | Line contents being refilled |

## Verification
A lookup driven before an edge has its response, hit flag, data and refill request during the cycle after that edge. The bench drives inputs on falling edges and reads the outputs at the next falling edge. A refill driven in one cycle becomes visible to a lookup accepted at the following edge. A size change made while reqValid is low takes effect at the next edge, so every size task waits one full cycle before the next lookup. To show that the width is held back, the bench keeps reqValid high across several edges after changing sizeSel and checks one result per falling edge. It then drops the request for a single cycle and verifies that the new width is in force.

// File: rtl/setsize_icache_pkg.sv
package setsize_icache_pkg;

  // Width of any index-width value carried between control and datapath.
  localparam int WIDTH_VAL_W = 4;

  // Strobes from control to datapath, one set per cycle.
  typedef struct packed {
    logic                   lookupEn;   // capture a lookup this edge
    logic                   refillEn;   // write one line this edge
    logic                   clearEn;    // shrink: drop sets at/above 2^keepWidth
    logic [WIDTH_VAL_W-1:0] keepWidth;  // width after a shrink
    logic [WIDTH_VAL_W-1:0] curWidth;   // width used for this cycle's indexing
  } icStrobes_t;

endpackage

// File: rtl/setsize_icache_ctrl.sv
module setsize_icache_ctrl
  import setsize_icache_pkg::*;
#(
  parameter int MIN_IDX_W = 3,
  parameter int MAX_IDX_W = 6,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] sizeSel,
  input  logic             reqValid,
  input  logic             refillValid,
  output icStrobes_t       strobes
);

  localparam logic [WIDTH_VAL_W-1:0] MIN_W = WIDTH_VAL_W'(MIN_IDX_W);
  localparam logic [WIDTH_VAL_W-1:0] MAX_W = WIDTH_VAL_W'(MAX_IDX_W);

  logic [WIDTH_VAL_W-1:0] activeWidth;
  logic [WIDTH_VAL_W-1:0] targetWidth;
  logic                   applyResize;
  logic                   shrinking;

  // Requested width, saturated at the largest allowed value.
  always_comb begin
    targetWidth = MIN_W + WIDTH_VAL_W'(sizeSel);
    if (targetWidth > MAX_W) targetWidth = MAX_W;
  end

  // A resize only lands on an edge where no lookup is being accepted.
  assign applyResize = !reqValid && (targetWidth != activeWidth);
  assign shrinking   = targetWidth < activeWidth;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeWidth <= MAX_W;
    end else if (applyResize) begin
      activeWidth <= targetWidth;
    end
  end

  always_comb begin
    strobes.lookupEn  = reqValid;
    strobes.refillEn  = refillValid;
    strobes.clearEn   = applyResize && shrinking;
    strobes.keepWidth = targetWidth;
    strobes.curWidth  = activeWidth;
  end

endmodule

// File: rtl/setsize_icache_datapath.sv
module setsize_icache_datapath
  import setsize_icache_pkg::*;
#(
  parameter int LADDR_W   = 14,
  parameter int LINE_W    = 32,
  parameter int MIN_IDX_W = 3,
  parameter int MAX_IDX_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  icStrobes_t         strobes,
  input  logic [LADDR_W-1:0] reqLine,
  input  logic [LADDR_W-1:0] refillLine,
  input  logic [LINE_W-1:0]  refillData,
  output logic               rspValid,
  output logic               rspHit,
  output logic [LINE_W-1:0]  rspData,
  output logic               refillReq,
  output logic [LADDR_W-1:0] refillReqLine
);

  localparam int SETS  = 1 << MAX_IDX_W;
  localparam int TAG_W = LADDR_W - MIN_IDX_W;

  // Index of a line under a given width: low bits kept, the rest masked.
  function automatic logic [MAX_IDX_W-1:0] setOf(
    input logic [MAX_IDX_W-1:0]   low,
    input logic [WIDTH_VAL_W-1:0] width
  );
    logic [MAX_IDX_W-1:0] mask;
    for (int i = 0; i < MAX_IDX_W; i++) begin
      mask[i] = (i < int'(width));
    end
    return low & mask;
  endfunction

  logic [SETS-1:0]    lineValid;
  logic [SETS-1:0]    keepMask;
  logic [TAG_W-1:0]   tagArr  [SETS];
  logic [LINE_W-1:0]  dataArr [SETS];

  logic [MAX_IDX_W-1:0] refSet;
  logic [TAG_W-1:0]     refTag;

  logic                 stValid;
  logic [LADDR_W-1:0]   stLine;
  logic [MAX_IDX_W-1:0] stSet;
  logic                 tagMatch;

  // Which sets survive a shrink to keepWidth.
  for (genvar s = 0; s < SETS; s++) begin : g_keep
    assign keepMask[s] = ((32'(s) >> strobes.keepWidth) == 32'd0);
  end

  assign refSet = setOf(refillLine[MAX_IDX_W-1:0], strobes.curWidth);
  assign refTag = refillLine[LADDR_W-1:MIN_IDX_W];

  // Valid bits: a shrink clear wins over a same-edge refill.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (strobes.clearEn && !keepMask[s]) begin
          lineValid[s] <= 1'b0;
        end else if (strobes.refillEn && (refSet == MAX_IDX_W'(s))) begin
          lineValid[s] <= 1'b1;
        end
      end
    end
  end

  // Tag and data storage, written together by a refill.
  always_ff @(posedge clk) begin
    if (strobes.refillEn) begin
      tagArr[refSet]  <= refTag;
      dataArr[refSet] <= refillData;
    end
  end

  // Lookup stage: index frozen with the width in force at acceptance.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stValid <= 1'b0;
      stLine  <= '0;
      stSet   <= '0;
    end else begin
      stValid <= strobes.lookupEn;
      if (strobes.lookupEn) begin
        stLine <= reqLine;
        stSet  <= setOf(reqLine[MAX_IDX_W-1:0], strobes.curWidth);
      end
    end
  end

  assign tagMatch      = (tagArr[stSet] == stLine[LADDR_W-1:MIN_IDX_W]);
  assign rspValid      = stValid;
  assign rspHit        = stValid && lineValid[stSet] && tagMatch;
  assign rspData       = dataArr[stSet];
  assign refillReq     = stValid && !rspHit;
  assign refillReqLine = stLine;

endmodule

// File: rtl/setsize_icache.sv
module setsize_icache
  import setsize_icache_pkg::*;
#(
  parameter  int LADDR_W   = 14,
  parameter  int LINE_W    = 32,
  parameter  int MIN_IDX_W = 3,
  parameter  int MAX_IDX_W = 6,
  localparam int SEL_W     = $clog2(MAX_IDX_W - MIN_IDX_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   sizeSel,
  input  logic               reqValid,
  input  logic [LADDR_W-1:0] reqLine,
  output logic               rspValid,
  output logic               rspHit,
  output logic [LINE_W-1:0]  rspData,
  output logic               refillReq,
  output logic [LADDR_W-1:0] refillReqLine,
  input  logic               refillValid,
  input  logic [LADDR_W-1:0] refillLine,
  input  logic [LINE_W-1:0]  refillData
);

  icStrobes_t strobes;

  setsize_icache_ctrl #(
    .MIN_IDX_W(MIN_IDX_W),
    .MAX_IDX_W(MAX_IDX_W),
    .SEL_W    (SEL_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sizeSel    (sizeSel),
    .reqValid   (reqValid),
    .refillValid(refillValid),
    .strobes    (strobes)
  );

  setsize_icache_datapath #(
    .LADDR_W  (LADDR_W),
    .LINE_W   (LINE_W),
    .MIN_IDX_W(MIN_IDX_W),
    .MAX_IDX_W(MAX_IDX_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .reqLine      (reqLine),
    .refillLine   (refillLine),
    .refillData   (refillData),
    .rspValid     (rspValid),
    .rspHit       (rspHit),
    .rspData      (rspData),
    .refillReq    (refillReq),
    .refillReqLine(refillReqLine)
  );

endmodule

// File: rtl/setsize_icache_chk.sv
module setsize_icache_chk
  import setsize_icache_pkg::*;
#(
  parameter int MIN_IDX_W = 3,
  parameter int MAX_IDX_W = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic                   rspValid,
  input logic                   rspHit,
  input logic                   refillReq,
  input logic [WIDTH_VAL_W-1:0] curWidth
);

  a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  a_r2_hit_needs_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspValid);

  a_r3_miss_raises_refill: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> refillReq);

  a_r3_refill_only_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    refillReq |-> (rspValid && !rspHit));

  a_r9_width_held_under_lookup: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> $stable(curWidth));

  a_r10_width_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (curWidth >= WIDTH_VAL_W'(MIN_IDX_W)) && (curWidth <= WIDTH_VAL_W'(MAX_IDX_W)));

endmodule

bind setsize_icache setsize_icache_chk #(
  .MIN_IDX_W(MIN_IDX_W),
  .MAX_IDX_W(MAX_IDX_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .rspValid (rspValid),
  .rspHit   (rspHit),
  .refillReq(refillReq),
  .curWidth (strobes.curWidth)
);

// File: tb/sim_setsize_icache.sv
module sim_setsize_icache;

  localparam int CLK_PERIOD = 10;
  localparam int LADDR_W    = 14;
  localparam int LINE_W     = 32;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [1:0]         sizeSel = 2'd3;
  logic               reqValid = 1'b0;
  logic [LADDR_W-1:0] reqLine = '0;
  logic               rspValid, rspHit, refillReq;
  logic [LINE_W-1:0]  rspData;
  logic [LADDR_W-1:0] refillReqLine;
  logic               refillValid = 1'b0;
  logic [LADDR_W-1:0] refillLine = '0;
  logic [LINE_W-1:0]  refillData = '0;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  setsize_icache u0 (
    .clk(clk), .rstN(rstN), .sizeSel(sizeSel),
    .reqValid(reqValid), .reqLine(reqLine),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData),
    .refillReq(refillReq), .refillReqLine(refillReqLine),
    .refillValid(refillValid), .refillLine(refillLine), .refillData(refillData)
  );

  function automatic logic [LADDR_W-1:0] mk(input logic [7:0] hi, input logic [5:0] idx);
    return {hi, idx};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One lookup; result read at the falling edge after the accepting edge.
  task automatic lookup(input string req, input logic [LADDR_W-1:0] line,
                        input logic expHit, input logic [LINE_W-1:0] expData);
    @(negedge clk);
    reqValid = 1'b1;
    reqLine  = line;
    @(negedge clk);
    check(req, "rspValid", 64'(rspValid), 64'd1);
    check(req, "rspHit", 64'(rspHit), 64'(expHit));
    if (expHit) begin
      check(req, "rspData", 64'(rspData), 64'(expData));
      check(req, "no refillReq on hit", 64'(refillReq), 64'd0);
    end else begin
      check(req, "refillReq on miss", 64'(refillReq), 64'd1);
      check(req, "refillReqLine", 64'(refillReqLine), 64'(line));
    end
    reqValid = 1'b0;
  endtask

  task automatic refill(input logic [LADDR_W-1:0] line, input logic [LINE_W-1:0] data);
    @(negedge clk);
    refillValid = 1'b1;
    refillLine  = line;
    refillData  = data;
    @(negedge clk);
    refillValid = 1'b0;
  endtask

  task automatic setSize(input logic [1:0] sel);
    @(negedge clk);
    sizeSel = sel;
    @(negedge clk);
  endtask

  localparam logic [LADDR_W-1:0] LA = {8'h12, 6'd5};
  localparam logic [LADDR_W-1:0] LB = {8'h34, 6'd5};
  localparam logic [LADDR_W-1:0] LD = {8'h01, 6'd13};
  localparam logic [LADDR_W-1:0] LG = {8'h55, 6'd15};
  localparam logic [LADDR_W-1:0] LH = {8'h66, 6'd16};

  task automatic testReset();
    @(negedge clk);
    check("R1", "rspValid after reset", 64'(rspValid), 64'd0);
    check("R1", "refillReq after reset", 64'(refillReq), 64'd0);
    lookup("R1", LA, 1'b0, '0);
    lookup("R1", mk(8'h00, 6'd63), 1'b0, '0);
  endtask

  task automatic testMissRefillHit();
    lookup("R3", LA, 1'b0, '0);
    refill(LA, 32'hA0A0_0001);
    lookup("R4", LA, 1'b1, 32'hA0A0_0001);
    lookup("R2", LA, 1'b1, 32'hA0A0_0001);
    // Refill immediately followed by a lookup at the next edge.
    @(negedge clk);
    refillValid = 1'b1; refillLine = mk(8'h77, 6'd40); refillData = 32'h4040_4040;
    @(negedge clk);
    refillValid = 1'b0;
    reqValid = 1'b1; reqLine = mk(8'h77, 6'd40);
    @(negedge clk);
    check("R4", "hit right after refill", 64'(rspHit), 64'd1);
    check("R4", "data right after refill", 64'(rspData), 64'h4040_4040);
    reqValid = 1'b0;
    @(negedge clk);
    check("R2", "rspValid drops", 64'(rspValid), 64'd0);
  endtask

  task automatic testAlias();
    lookup("R5", LB, 1'b0, '0);
    refill(LB, 32'hB0B0_0002);
    lookup("R5", LB, 1'b1, 32'hB0B0_0002);
    lookup("R5", LA, 1'b0, '0);
    refill(LA, 32'hA0A0_0003);
    lookup("R5", LA, 1'b1, 32'hA0A0_0003);
  endtask

  task automatic testShrink();
    refill(LD, 32'hD0D0_0004);
    setSize(2'd0);                                  // R10: width 3, 8 sets
    lookup("R7", LA, 1'b1, 32'hA0A0_0003);          // set 5 kept
    lookup("R6", mk(8'h12, 6'd13), 1'b0, '0);       // folds onto set 5
    lookup("R6", LD, 1'b0, '0);
  endtask

  task automatic testRegrow();
    setSize(2'd3);
    lookup("R8", LD, 1'b0, '0);                     // set 13 came back empty
    lookup("R7", LA, 1'b1, 32'hA0A0_0003);
  endtask

  task automatic testDeferredResize();
    refill(LD, 32'hD0D0_0005);
    @(negedge clk);
    reqValid = 1'b1; reqLine = LD;
    @(negedge clk);
    check("R9", "hit before resize", 64'(rspHit), 64'd1);
    sizeSel = 2'd0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9", "old width kept under lookups", 64'(rspHit), 64'd1);
      check("R9", "data under old width", 64'(rspData), 64'hD0D0_0005);
    end
    reqValid = 1'b0;
    @(negedge clk);                                 // resize lands here
    lookup("R9", LD, 1'b0, '0);
    setSize(2'd3);
  endtask

  task automatic testMidWidth();
    refill(LG, 32'h6060_0006);
    refill(LH, 32'h7070_0007);
    setSize(2'd1);                                  // R10: width 4, 16 sets
    lookup("R10", LG, 1'b1, 32'h6060_0006);         // set 15 is last kept
    lookup("R10", LH, 1'b0, '0);
    setSize(2'd3);
    lookup("R8", LH, 1'b0, '0);                     // set 16 was cleared
    lookup("R8", LG, 1'b1, 32'h6060_0006);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMissRefillHit();
    testAlias();
    testShrink();
    testRegrow();
    testDeferredResize();
    testMidWidth();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule